// File: doc/BRIEF.md
# Node State Control Register

This block holds the control and status word of a serial-bus node. Only three bits in the word are kept: a request-disable flag, a cycle-master flag and an abdicate flag. Software changes the word through two write ports. The set port ORs its masked value into the word. The clear port removes the masked bits from the word. All other bit positions are dropped on write and always read back as zero.

The block also applies the rules the node must follow when the bus is reset. It keeps a flag that records whether the node was root at the previous bus reset. That flag, the current root indication and a cycle-master-capable strap decide how the cycle-master bit changes.

The block drives a cycle-start-generation enable. This enable follows the cycle-master bit while the node is root, and it is forced low whenever the node is not root.

Top module: `node_state_reg`

## Requirements
- R1: After synchronous reset, the read value is all zeros, the cycle-start enable is low and the remembered was-root flag is clear.
- R2: Only bit 2 (request-disable), bit 8 (cycle-master) and bit 10 (abdicate) are stored. Every other bit reads as zero, and writing to it has no effect.
- R3: When set_en is high, the supported bits of set_data are ORed into the word. The result is visible one cycle later.
- R4: When clr_en is high, the word loses every supported bit that is one in clr_data. If both ports are active in the same cycle, the clear is applied after the set.
- R5: While is_root is high, setting bit 8 raises the cycle-start enable on the next cycle, and clearing bit 8 lowers it on the next cycle.
- R6: The cycle-start enable is low in the cycle after any cycle in which is_root is low, whatever the value of the cycle-master bit.
- R7: A bus reset pulse clears the abdicate bit in every case.
- R8: A bus reset while not root clears the cycle-master bit and the was-root flag, and the enable goes low.
- R9: A bus reset while root that follows a reset while not root (or the initial reset) sets the was-root flag. The cycle-master bit and the enable then both take the value of cm_capable.
- R10: A bus reset while root, when the node was already root at the previous bus reset, leaves the cycle-master bit and the enable unchanged.
- R11: Writes presented in the same cycle as a bus reset pulse are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_en | input | 1 | Bit-set write strobe |
| set_data | input | DATA_W | Bits to set |
| clr_en | input | 1 | Bit-clear write strobe |
| clr_data | input | DATA_W | Bits to clear |
| bus_reset | input | 1 | One-cycle bus reset event |
| is_root | input | 1 | Node is currently root |
| cm_capable | input | 1 | Node can act as cycle master (strap) |
| state_rd | output | DATA_W | Registered state word |
| cycle_start_en | output | 1 | Registered cycle-start generation enable |

## Verification
Every result of this block comes out of a single register stage. A write, a bus reset or a change of is_root therefore shows up on state_rd and cycle_start_en at the first rising edge after the stimulus, and not before. The bench changes its inputs on the falling edge. At each rising edge it advances a behavioural model by one step, using the inputs that were held at that edge. It compares both outputs with the model on the following falling edge, so every comparison lands in the cycle where the new value is due. A one-cycle-early or one-cycle-late response would show up as a mismatch in that same comparison.

// File: rtl/node_state_pkg.sv
package node_state_pkg;
  typedef enum logic [1:0] {
    BR_NONE       = 2'd0,
    BR_NOT_ROOT   = 2'd1,
    BR_NEW_ROOT   = 2'd2,
    BR_STILL_ROOT = 2'd3
  } br_kind_e;
endpackage

// File: rtl/root_tracker.sv
module root_tracker
  import node_state_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     bus_reset,
  input  logic     is_root,
  output br_kind_e br_kind,
  output logic     was_root
);
  always_comb begin
    if (!bus_reset)     br_kind = BR_NONE;
    else if (!is_root)  br_kind = BR_NOT_ROOT;
    else if (!was_root) br_kind = BR_NEW_ROOT;
    else                br_kind = BR_STILL_ROOT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      was_root <= 1'b0;
    end else begin
      case (br_kind)
        BR_NOT_ROOT: was_root <= 1'b0;
        BR_NEW_ROOT: was_root <= 1'b1;
        default:     was_root <= was_root;
      endcase
    end
  end

  // R8: a reset while not root leaves the flag clear
  p_wasroot_clr_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bus_reset && !is_root) |-> !was_root);
  // R9: a reset while root leaves the flag set
  p_wasroot_set_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bus_reset && is_root) |-> was_root);
endmodule

// File: rtl/state_bits.sv
module state_bits
  import node_state_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DREQ_BIT  = 2,
  parameter int CMSTR_BIT = 8,
  parameter int ABD_BIT   = 10
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [DATA_W-1:0] set_data,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_data,
  input  br_kind_e          br_kind,
  input  logic              cm_capable,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] KEEP_MASK =
    (DATA_W'(1) << DREQ_BIT) | (DATA_W'(1) << CMSTR_BIT) | (DATA_W'(1) << ABD_BIT);

  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = q;
    case (br_kind)
      BR_NONE: begin
        if (set_en) nxt = nxt | (set_data & KEEP_MASK);
        if (clr_en) nxt = nxt & ~(clr_data & KEEP_MASK);
      end
      BR_NOT_ROOT: begin
        nxt[ABD_BIT]   = 1'b0;
        nxt[CMSTR_BIT] = 1'b0;
      end
      BR_NEW_ROOT: begin
        nxt[ABD_BIT]   = 1'b0;
        nxt[CMSTR_BIT] = cm_capable;
      end
      default: nxt[ABD_BIT] = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R3: bits written through the set port are present next cycle
  p_set_or_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && br_kind == BR_NONE && set_en && !clr_en)
      |-> ((q & $past(set_data) & KEEP_MASK) == ($past(set_data) & KEEP_MASK)));
  // R4: bits named by the clear port are gone next cycle
  p_clr_andnot_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && br_kind == BR_NONE && clr_en)
      |-> ((q & $past(clr_data) & KEEP_MASK) == '0));
  // R7: abdicate is low after any bus reset
  p_abd_clr_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && br_kind != BR_NONE) |-> !q[ABD_BIT]);
  // R10: still-root bus reset keeps cycle-master bit
  p_cm_keep_r10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && br_kind == BR_STILL_ROOT) |-> (q[CMSTR_BIT] == $past(q[CMSTR_BIT])));
endmodule

// File: rtl/cycle_start_ctl.sv
module cycle_start_ctl
  import node_state_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     is_root,
  input  logic     set_cm,
  input  logic     clr_cm,
  input  br_kind_e br_kind,
  input  logic     cm_capable,
  output logic     cse
);
  logic nxt;

  always_comb begin
    nxt = cse;
    case (br_kind)
      BR_NONE: begin
        if (set_cm) nxt = 1'b1;
        if (clr_cm) nxt = 1'b0;
      end
      BR_NEW_ROOT: nxt = cm_capable;
      BR_NOT_ROOT: nxt = 1'b0;
      default:     nxt = cse;
    endcase
    if (!is_root) nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) cse <= 1'b0;
    else     cse <= nxt;
  end

  // R6: no cycle start after a non-root cycle
  p_off_not_root_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!is_root) |-> !cse);
  // R5: setting cycle-master while root turns generation on
  p_set_on_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && is_root && br_kind == BR_NONE && set_cm && !clr_cm) |-> cse);
  // R5: clearing cycle-master while root turns generation off
  p_clr_off_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && br_kind == BR_NONE && clr_cm) |-> !cse);
endmodule

// File: rtl/node_state_reg.sv
module node_state_reg
  import node_state_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DREQ_BIT  = 2,
  parameter int CMSTR_BIT = 8,
  parameter int ABD_BIT   = 10
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [DATA_W-1:0] set_data,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_data,
  input  logic              bus_reset,
  input  logic              is_root,
  input  logic              cm_capable,
  output logic [DATA_W-1:0] state_rd,
  output logic              cycle_start_en
);
  br_kind_e br_kind;
  logic     was_root;

  root_tracker u_root (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .is_root(is_root),
    .br_kind(br_kind), .was_root(was_root)
  );

  state_bits #(
    .DATA_W(DATA_W), .DREQ_BIT(DREQ_BIT), .CMSTR_BIT(CMSTR_BIT), .ABD_BIT(ABD_BIT)
  ) u_bits (
    .clk(clk), .rst(rst), .set_en(set_en), .set_data(set_data),
    .clr_en(clr_en), .clr_data(clr_data), .br_kind(br_kind),
    .cm_capable(cm_capable), .q(state_rd)
  );

  cycle_start_ctl u_cs (
    .clk(clk), .rst(rst), .is_root(is_root),
    .set_cm(set_en && set_data[CMSTR_BIT]),
    .clr_cm(clr_en && clr_data[CMSTR_BIT]),
    .br_kind(br_kind), .cm_capable(cm_capable), .cse(cycle_start_en)
  );

  // R1: after reset the flag is clear
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!was_root && state_rd == '0 && !cycle_start_en));
endmodule

// File: tb/tb_node_state_reg.sv
module tb_node_state_reg;
  localparam int W = 32;
  localparam int DQ = 2, CM = 8, AB = 10;

  logic clk = 1'b0;
  logic rst, set_en, clr_en, bus_reset, is_root, cm_capable;
  logic [W-1:0] set_data, clr_data, state_rd;
  logic cycle_start_en;

  always #10 clk = ~clk;

  node_state_reg dut (
    .clk(clk), .rst(rst), .set_en(set_en), .set_data(set_data),
    .clr_en(clr_en), .clr_data(clr_data), .bus_reset(bus_reset),
    .is_root(is_root), .cm_capable(cm_capable),
    .state_rd(state_rd), .cycle_start_en(cycle_start_en)
  );

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit m_dq, m_cm, m_ab, m_was, m_cse;

  function automatic logic [W-1:0] model_word();
    logic [W-1:0] w = '0;
    w[DQ] = m_dq; w[CM] = m_cm; w[AB] = m_ab;
    return w;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // reference update, one step per rising edge
  task automatic model_step();
    if (rst) begin
      m_dq = 0; m_cm = 0; m_ab = 0; m_was = 0; m_cse = 0;
    end else if (bus_reset) begin
      m_ab = 0;
      if (!is_root) begin
        m_was = 0; m_cm = 0; m_cse = 0;
      end else if (!m_was) begin
        m_was = 1; m_cm = cm_capable; m_cse = cm_capable;
      end
    end else begin
      if (set_en) begin
        if (set_data[DQ]) m_dq = 1;
        if (set_data[CM]) begin m_cm = 1; m_cse = 1; end
        if (set_data[AB]) m_ab = 1;
      end
      if (clr_en) begin
        if (clr_data[DQ]) m_dq = 0;
        if (clr_data[CM]) begin m_cm = 0; m_cse = 0; end
        if (clr_data[AB]) m_ab = 0;
      end
    end
    if (!is_root) m_cse = 0;
  endtask

  // one cycle: inputs already driven, then edge, then compare at falling edge
  task automatic cycle(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({tag, " state"}, state_rd, model_word());
    check({tag, " cse"}, W'(cycle_start_en), W'(m_cse));
    set_en = 0; clr_en = 0; bus_reset = 0;
  endtask

  task automatic do_set(logic [W-1:0] d, string tag);
    set_en = 1; set_data = d; cycle(tag);
  endtask

  task automatic do_clr(logic [W-1:0] d, string tag);
    clr_en = 1; clr_data = d; cycle(tag);
  endtask

  task automatic do_br(string tag);
    bus_reset = 1; cycle(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    rst = 1; set_en = 0; clr_en = 0; bus_reset = 0; is_root = 0; cm_capable = 1;
    set_data = '0; clr_data = '0;
    @(negedge clk);
    cycle("R1");
    cycle("R1");
    rst = 0;
    check("R1 reset word", state_rd, '0);
    cycle("R1");
    // R2/R3: all ones, only supported bits stick
    do_set('1, "R2");
    check("R2 masked", state_rd, (W'(1) << DQ) | (W'(1) << CM) | (W'(1) << AB));
    check("R6 not root", W'(cycle_start_en), '0);
    do_clr(W'(1) << DQ, "R4");
    do_set(W'(1) << DQ, "R3");
    // R4: set and clear together, clear wins
    set_en = 1; set_data = W'(1) << DQ; clr_en = 1; clr_data = W'(1) << DQ; cycle("R4");
    check("R4 order", W'(state_rd[DQ]), '0);
    do_clr('1, "R4");
    // R5: root writes of cycle-master
    is_root = 1; cycle("R6");
    do_set(W'(1) << CM, "R5");
    check("R5 on", W'(cycle_start_en), W'(1));
    do_clr(W'(1) << CM, "R5");
    check("R5 off", W'(cycle_start_en), '0);
    do_set(W'(1) << CM, "R5");
    is_root = 0; cycle("R6");
    check("R6 drop", W'(cycle_start_en), '0);
    // R7/R8: bus reset while not root
    do_set(W'(1) << AB, "R3");
    do_br("R8");
    check("R7 abd", W'(state_rd[AB]), '0);
    check("R8 cm", W'(state_rd[CM]), '0);
    // R9: new root, capable
    is_root = 1;
    do_br("R9");
    check("R9 cm", W'(state_rd[CM]), W'(1));
    check("R9 cse", W'(cycle_start_en), W'(1));
    // R10: still root keeps value both ways
    do_clr(W'(1) << CM, "R5");
    do_set(W'(1) << AB, "R3");
    do_br("R10");
    check("R10 keep0", W'(state_rd[CM]), '0);
    check("R7 abd root", W'(state_rd[AB]), '0);
    do_set(W'(1) << CM, "R5");
    do_br("R10");
    check("R10 keep1", W'(state_rd[CM]), W'(1));
    // R9: new root, not capable
    is_root = 0; do_br("R8");
    is_root = 1; cm_capable = 0;
    do_br("R9");
    check("R9 nocap", W'(state_rd[CM]), '0);
    check("R9 nocap cse", W'(cycle_start_en), '0);
    // R11: write in bus reset cycle dropped
    set_en = 1; set_data = W'(1) << DQ; bus_reset = 1; cycle("R11");
    check("R11 drop", W'(state_rd[DQ]), '0);
    // R2: unsupported-only write leaves word
    do_set(W'(32'hFFFF_FAFB), "R2");
    check("R2 ignored", state_rd, '0);
    // R1: reset again from busy state
    do_set('1, "R3");
    rst = 1; cycle("R1"); rst = 0;
    check("R1 rereset", state_rd, '0);
    cycle("R1");
    finish_run();
  end
endmodule